// File: doc/BRIEF.md
# Byte-Stream Register-Write Sequencer

This block runs short programs that reprogram a set of control registers without any help from the host during the run. A typical use is a clock change. The program waits for display blanking, blocks bus traffic, and writes a series of control words. It then holds for a fixed settling time, writes further words and releases the bus. The program is a packed stream of bytes held in a 512-byte local memory. Host software fills this memory through a byte write port, pulses `kick`, and then polls the busy bit of `status` until it clears.

Register writes use a compact delta encoding. The engine holds a sticky value shadow and a sticky address shadow. An opcode can replace the low 16 bits of a shadow or the whole 32 bits of it. Each opcode that updates the address shadow also issues one write of the value shadow to the new address on a simple valid/ready master port. The remaining opcodes wait on external condition inputs, assert or release a bus-block output, or insert a fixed settle delay.

Top module: `regseq_top`

## Requirements
- R1: After reset, status bit 8 (busy) and bit 0 (done) are 0, `bus_valid` is 0 and `bus_block` is 0. Both shadow registers reset to 0xFFFFFFFF.
- R2: A `kick` pulse while idle starts execution at byte 0, sets busy and clears done. A `kick` while busy has no effect on the running program. Done sets when the program ends and stays set until the next accepted kick.
- R3: Opcode 0x42 with a 16-bit little-endian operand replaces only bits 15:0 of the value shadow and keeps bits 31:16. Opcode 0xE2 with a 32-bit little-endian operand replaces the whole value shadow. Shadows persist from one run to the next.
- R4: Opcode 0x40 with a 16-bit little-endian operand replaces bits 15:0 of the address shadow. Opcode 0xE0 with a 32-bit operand replaces the whole address shadow. Each of these then issues exactly one bus write of the value shadow to the new address.
- R5: During a bus write, `bus_valid`, `bus_addr` and `bus_data` stay asserted and stable until `bus_ready` is sampled high. No later opcode executes before that.
- R6: Opcode 0x5F takes a mask byte and then a level byte. The engine stalls until every condition input selected by the mask equals bit 0 of the level byte. A zero mask passes after one wait cycle.
- R7: Opcode 0xB0 sets `bus_block` and opcode 0xD0 clears it. `bus_block` keeps its value across the end of a run.
- R8: Opcode 0x07 holds execution for exactly SETTLE_CYC cycles. The program 07 7F keeps busy high for SETTLE_CYC+2 cycles.
- R9: Execution ends on the first 0x7F opcode, or when the byte pointer runs past the last memory byte. Every one-byte opcode takes one cycle and ending takes one cycle, so 512 no-op bytes keep busy high for 513 cycles.
- R10: Every byte value other than 0x07, 0x40, 0x42, 0x5F, 0x7F, 0xB0, 0xD0, 0xE0 and 0xE2 is a one-cycle no-op with no bus write and no change to `bus_block`.
- R11: An opcode whose operand bytes run past the end of memory is abandoned. No write is issued and the run ends with done set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Program memory byte write enable |
| prog_addr | input | 9 | Program memory byte address |
| prog_wdata | input | 8 | Program memory byte data |
| kick | input | 1 | Start pulse |
| cond_in | input | COND_W | Condition inputs tested by the wait opcode |
| bus_ready | input | 1 | Write slave accepts the current write |
| bus_valid | output | 1 | Write request pending |
| bus_addr | output | 32 | Write address (address shadow) |
| bus_data | output | 32 | Write data (value shadow) |
| bus_block | output | 1 | Bus-access-disable level |
| status | output | 32 | Bit 8 busy, bit 0 done, other bits 0 |

## Verification
The hardest state to reach is an opcode whose operands are cut off by the end of memory. The stimulus reaches it by filling 511 bytes with no-ops and placing a 32-bit address opcode in the final byte. The sticky shadow encoding is exercised by a bench-side encoder that picks the short or long form from its own model of both shadows. This gives long write streams in which the high halves are sometimes kept and sometimes replaced, and the streams are replayed under delayed `bus_ready`. The wait opcode is driven with a mask covering two inputs that rise one at a time, to show that a partial match does not release the stall.

// File: rtl/regseq_pkg.sv
package regseq_pkg;

    localparam logic [7:0] OP_VAL_LO   = 8'h42;
    localparam logic [7:0] OP_VAL_FULL = 8'hE2;
    localparam logic [7:0] OP_ADR_LO   = 8'h40;
    localparam logic [7:0] OP_ADR_FULL = 8'hE0;
    localparam logic [7:0] OP_WAIT     = 8'h5F;
    localparam logic [7:0] OP_BLOCK    = 8'hB0;
    localparam logic [7:0] OP_UNBLOCK  = 8'hD0;
    localparam logic [7:0] OP_SETTLE   = 8'h07;
    localparam logic [7:0] OP_END      = 8'h7F;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_OPND,
        S_WAIT,
        S_SETTLE,
        S_WRITE
    } seq_state_e;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] data;
    } wr_req_t;

    // number of operand bytes following an opcode
    function automatic logic [2:0] opnd_len(input logic [7:0] op);
        case (op)
            OP_VAL_LO, OP_ADR_LO, OP_WAIT: opnd_len = 3'd2;
            OP_VAL_FULL, OP_ADR_FULL:      opnd_len = 3'd4;
            default:                       opnd_len = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/regseq_mem.sv
module regseq_mem #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] bytes_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) bytes_q[waddr] <= wdata;
    end

    assign rdata = bytes_q[raddr];
endmodule

// File: rtl/regseq_timer.sv
module regseq_timer #(
    parameter int CYC = 600
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic zero
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] START = CW'(CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= START;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/regseq_ctrl.sv
module regseq_ctrl
    import regseq_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int AW     = $clog2(DEPTH),
    parameter int COND_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              kick,
    input  logic [7:0]        rd_byte,
    output logic [AW:0]       pc,
    input  logic [COND_W-1:0] cond_in,
    input  logic              bus_ready,
    input  logic              tmr_zero,
    output logic              tmr_load,
    output wr_req_t           req,
    output logic              bus_valid,
    output logic              bus_block,
    output logic              busy,
    output logic              done
);
    localparam logic [AW:0] PC_END = (AW + 1)'(DEPTH);

    seq_state_e        state;
    logic [7:0]        opc;
    logic [31:0]       imm, imm_nx;
    logic [1:0]        idx;
    logic [31:0]       val_sh, adr_sh;
    logic [COND_W-1:0] mask;
    logic              lvl;
    logic              last_opnd, at_end, cond_ok;

    always_comb begin
        imm_nx = imm;
        imm_nx[{idx, 3'b000} +: 8] = rd_byte;
    end

    assign last_opnd = ({1'b0, idx} + 3'd1) == opnd_len(opc);
    assign at_end    = (pc == PC_END);
    assign cond_ok   = ((cond_in ^ {COND_W{lvl}}) & mask) == '0;
    assign tmr_load  = (state == S_FETCH) && !at_end && (rd_byte == OP_SETTLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            pc        <= '0;
            opc       <= '0;
            imm       <= '0;
            idx       <= '0;
            val_sh    <= '1;
            adr_sh    <= '1;
            mask      <= '0;
            lvl       <= 1'b0;
            bus_block <= 1'b0;
            done      <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (kick) begin
                    pc    <= '0;
                    done  <= 1'b0;
                    state <= S_FETCH;
                end
                S_FETCH: if (at_end || rd_byte == OP_END) begin
                    state <= S_IDLE;
                    done  <= 1'b1;
                end else begin
                    opc <= rd_byte;
                    pc  <= pc + 1'b1;
                    idx <= '0;
                    case (rd_byte)
                        OP_VAL_LO, OP_VAL_FULL, OP_ADR_LO,
                        OP_ADR_FULL, OP_WAIT: state <= S_OPND;
                        OP_BLOCK:             bus_block <= 1'b1;
                        OP_UNBLOCK:           bus_block <= 1'b0;
                        OP_SETTLE:            state <= S_SETTLE;
                        default:              ;
                    endcase
                end
                S_OPND: if (at_end) begin
                    state <= S_IDLE;
                    done  <= 1'b1;
                end else begin
                    imm <= imm_nx;
                    pc  <= pc + 1'b1;
                    idx <= idx + 1'b1;
                    if (last_opnd) begin
                        case (opc)
                            OP_VAL_LO: begin
                                val_sh[15:0] <= imm_nx[15:0];
                                state <= S_FETCH;
                            end
                            OP_VAL_FULL: begin
                                val_sh <= imm_nx;
                                state  <= S_FETCH;
                            end
                            OP_ADR_LO: begin
                                adr_sh[15:0] <= imm_nx[15:0];
                                state <= S_WRITE;
                            end
                            OP_ADR_FULL: begin
                                adr_sh <= imm_nx;
                                state  <= S_WRITE;
                            end
                            default: begin
                                mask  <= imm_nx[COND_W-1:0];
                                lvl   <= imm_nx[8];
                                state <= S_WAIT;
                            end
                        endcase
                    end
                end
                S_WAIT:   if (cond_ok)   state <= S_FETCH;
                S_SETTLE: if (tmr_zero)  state <= S_FETCH;
                S_WRITE:  if (bus_ready) state <= S_FETCH;
                default:  state <= S_IDLE;
            endcase
        end
    end

    assign req       = '{addr: adr_sh, data: val_sh};
    assign bus_valid = (state == S_WRITE);
    assign busy      = (state != S_IDLE);
endmodule

// File: rtl/regseq_top.sv
module regseq_top
    import regseq_pkg::*;
#(
    parameter int PROG_BYTES = 512,
    parameter int COND_W     = 4,
    parameter int SETTLE_CYC = 600
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_we,
    input  logic [8:0]        prog_addr,
    input  logic [7:0]        prog_wdata,
    input  logic              kick,
    input  logic [COND_W-1:0] cond_in,
    input  logic              bus_ready,
    output logic              bus_valid,
    output logic [31:0]       bus_addr,
    output logic [31:0]       bus_data,
    output logic              bus_block,
    output logic [31:0]       status
);
    localparam int AW = $clog2(PROG_BYTES);

    logic [7:0]  rd_byte;
    logic [AW:0] pc;
    logic        tmr_load, tmr_zero, busy, done;
    wr_req_t     req;

    regseq_mem #(.DEPTH(PROG_BYTES), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (prog_we),
        .waddr (prog_addr[AW-1:0]),
        .wdata (prog_wdata),
        .raddr (pc[AW-1:0]),
        .rdata (rd_byte)
    );

    regseq_timer #(.CYC(SETTLE_CYC)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .zero (tmr_zero)
    );

    regseq_ctrl #(.DEPTH(PROG_BYTES), .AW(AW), .COND_W(COND_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .kick      (kick),
        .rd_byte   (rd_byte),
        .pc        (pc),
        .cond_in   (cond_in),
        .bus_ready (bus_ready),
        .tmr_zero  (tmr_zero),
        .tmr_load  (tmr_load),
        .req       (req),
        .bus_valid (bus_valid),
        .bus_block (bus_block),
        .busy      (busy),
        .done      (done)
    );

    assign bus_addr = req.addr;
    assign bus_data = req.data;

    always_comb begin
        status    = '0;
        status[8] = busy;
        status[0] = done;
    end
endmodule

// File: rtl/regseq_chk.sv
module regseq_chk (
    input logic        clk,
    input logic        rst,
    input logic        kick,
    input logic        bus_valid,
    input logic        bus_ready,
    input logic [31:0] bus_addr,
    input logic [31:0] bus_data,
    input logic        bus_block,
    input logic        busy,
    input logic        done
);
    p_write_hold_r5: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_data));

    p_write_in_run_r4: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> busy);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_kick_start_r2: assert property (@(posedge clk) disable iff (rst)
        kick && !busy |=> busy && !done);

    p_block_in_run_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(bus_block) |-> $past(busy));
endmodule

bind regseq_top regseq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .kick      (kick),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_addr  (bus_addr),
    .bus_data  (bus_data),
    .bus_block (bus_block),
    .busy      (status[8]),
    .done      (status[0])
);

// File: tb/sim_regseq_top.sv
module sim_regseq_top;
    localparam int SETTLE = 20;
    localparam int CW     = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_we = 1'b0;
    logic [8:0]  prog_addr = '0;
    logic [7:0]  prog_wdata = '0;
    logic        kick = 1'b0;
    logic [CW-1:0] cond_in = '0;
    logic        bus_ready = 1'b0;
    logic        bus_valid, bus_block;
    logic [31:0] bus_addr, bus_data, status;

    regseq_top #(.PROG_BYTES(512), .COND_W(CW), .SETTLE_CYC(SETTLE)) u0 (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_wdata(prog_wdata), .kick(kick), .cond_in(cond_in),
        .bus_ready(bus_ready), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_block(bus_block), .status(status)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    logic [7:0]  img [512];
    int          plen;
    logic [31:0] exp_a [64], exp_d [64], got_a [64], got_d [64];
    int          n_exp, n_got, busy_cyc;
    logic [31:0] m_val = '1, m_adr = '1;
    bit          hold_bad, timed_out;
    int          ca1 = -1, ca2 = -1, kick_at = -1;
    logic [CW-1:0] cv1, cv2;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic clear_img(input logic [7:0] b);
        for (int i = 0; i < 512; i++) img[i] = b;
        plen = 0;
    endtask

    task automatic put(input logic [7:0] b);
        img[plen] = b;
        plen++;
    endtask

    task automatic load_img();
        for (int i = 0; i < 512; i++) begin
            @(negedge clk);
            prog_we = 1'b1; prog_addr = 9'(i); prog_wdata = img[i];
        end
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    // encoder model: short form when the high half already matches
    task automatic enc_write(input logic [31:0] a, input logic [31:0] v);
        if (v != m_val) begin
            if (v[31:16] == m_val[31:16]) begin
                put(8'h42); put(v[7:0]); put(v[15:8]);
            end else begin
                put(8'hE2); put(v[7:0]); put(v[15:8]); put(v[23:16]); put(v[31:24]);
            end
            m_val = v;
        end
        if (a[31:16] == m_adr[31:16]) begin
            put(8'h40); put(a[7:0]); put(a[15:8]);
        end else begin
            put(8'hE0); put(a[7:0]); put(a[15:8]); put(a[23:16]); put(a[31:24]);
        end
        m_adr = a;
        exp_a[n_exp] = a; exp_d[n_exp] = v; n_exp++;
    endtask

    task automatic run(input int rdy_lat, input int limit);
        int hold;
        logic [31:0] ha, hd;
        hold = 0; n_got = 0; busy_cyc = 0; hold_bad = 0; timed_out = 0;
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
        chk(status[8] && !status[0], "R2 busy set, done cleared after kick", status, 32'h100);
        while (status[8]) begin
            busy_cyc++;
            if (busy_cyc == ca1) cond_in = cv1;
            if (busy_cyc == ca2) cond_in = cv2;
            kick = (busy_cyc == kick_at);
            if (bus_valid) begin
                if (hold == 0) begin ha = bus_addr; hd = bus_data; end
                else if (bus_addr != ha || bus_data != hd) hold_bad = 1;
                if (hold >= rdy_lat) begin
                    bus_ready = 1'b1;
                    if (n_got < 64) begin got_a[n_got] = bus_addr; got_d[n_got] = bus_data; end
                    n_got++; hold = 0;
                end else begin
                    bus_ready = 1'b0; hold++;
                end
            end else begin
                bus_ready = 1'b0; hold = 0;
            end
            if (busy_cyc > limit) begin timed_out = 1; break; end
            @(negedge clk);
        end
        kick = 1'b0; bus_ready = 1'b0;
        ca1 = -1; ca2 = -1; kick_at = -1;
        chk(!timed_out, "run finished", 32'(busy_cyc), 32'(limit));
        chk(status[0] == 1'b1, "R2 done set at end", status, 32'h1);
    endtask

    task automatic check_writes(input string tag);
        chk(n_got == n_exp, tag, 32'(n_got), 32'(n_exp));
        for (int i = 0; i < n_exp && i < n_got; i++) begin
            chk(got_a[i] == exp_a[i], tag, got_a[i], exp_a[i]);
            chk(got_d[i] == exp_d[i], tag, got_d[i], exp_d[i]);
        end
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(status == 32'h0, "R1 status after reset", status, 0);
        chk(!bus_valid && !bus_block, "R1 bus idle after reset", {bus_valid, bus_block}, 0);
        chk(bus_addr == '1 && bus_data == '1, "R1 shadows all ones", bus_data, 32'hFFFFFFFF);

        // R3 R4 R5 write sweep, immediate ready
        clear_img(8'h7F); n_exp = 0;
        for (int k = 0; k < 24; k++) begin
            logic [31:0] v, a;
            v = (k % 3 == 0) ? {m_val[31:16], 16'(k * 4099 + 7)} : 32'h9E3779B9 * 32'(k + 1);
            a = (k % 2 == 1) ? {m_adr[31:16], 16'(k * 257 + 4)} : 32'h0010_0000 + 32'(k * 4096);
            enc_write(a, v);
        end
        load_img();
        run(0, 2000);
        check_writes("R3 R4 write stream");

        // same style, slow slave: R5 hold and order
        clear_img(8'h7F); n_exp = 0;
        for (int k = 0; k < 16; k++) begin
            logic [31:0] v, a;
            v = (k % 2 == 0) ? {m_val[31:16], 16'(k * 911)} : 32'hA5A5_0000 ^ 32'(k * 65537 * 3);
            a = {m_adr[31:16] + 16'(k % 3 == 0), 16'(k * 8)};
            enc_write(a, v);
        end
        load_img();
        run(3, 3000);
        check_writes("R5 writes under backpressure");
        chk(!hold_bad, "R5 address/data stable while waiting", 32'(hold_bad), 0);

        // R8 settle delay, and R2 kick ignored while busy
        clear_img(8'h7F); put(8'h07); load_img();
        run(0, 200);
        chk(busy_cyc == SETTLE + 2, "R8 settle length", 32'(busy_cyc), 32'(SETTLE + 2));
        kick_at = 5; run(0, 200);
        chk(busy_cyc == SETTLE + 2, "R2 kick while busy ignored", 32'(busy_cyc), 32'(SETTLE + 2));
        repeat (10) @(negedge clk);
        chk(status[0] == 1'b1, "R2 done sticky while idle", status, 1);

        // R6 wait: mask 3 level 1, inputs rise one at a time
        clear_img(8'h7F); put(8'h5F); put(8'h03); put(8'h01); load_img();
        cond_in = '0; ca1 = 10; cv1 = 4'h1; ca2 = 20; cv2 = 4'h3;
        run(0, 200);
        chk(busy_cyc == 21, "R6 stall until all masked inputs match", 32'(busy_cyc), 21);
        // level 0
        clear_img(8'h7F); put(8'h5F); put(8'h01); put(8'h00); load_img();
        cond_in = 4'hF; ca1 = 8; cv1 = 4'hE;
        run(0, 200);
        chk(busy_cyc == 9, "R6 low level wait", 32'(busy_cyc), 9);
        // zero mask
        clear_img(8'h7F); put(8'h5F); put(8'h00); put(8'h01); load_img();
        cond_in = 4'h0;
        run(0, 200);
        chk(busy_cyc == 5, "R6 zero mask passes", 32'(busy_cyc), 5);

        // R7 block / unblock
        clear_img(8'h7F); put(8'hB0); load_img();
        run(0, 50);
        chk(bus_block == 1'b1, "R7 block set", 32'(bus_block), 1);
        clear_img(8'h7F); put(8'h55); load_img();
        run(0, 50);
        chk(bus_block == 1'b1, "R7 block kept by other op", 32'(bus_block), 1);
        clear_img(8'h7F); put(8'hD0); load_img();
        run(0, 50);
        chk(bus_block == 1'b0, "R7 block cleared", 32'(bus_block), 0);

        // R10 sweep every non-opcode byte
        begin
            int n;
            n = 0;
            clear_img(8'h7F);
            for (int b = 0; b < 256; b++) begin
                if (!(b inside {8'h07, 8'h40, 8'h42, 8'h5F, 8'h7F, 8'hB0, 8'hD0, 8'hE0, 8'hE2})) begin
                    put(8'(b)); n++;
                end
            end
            load_img();
            run(0, 1000);
            chk(busy_cyc == n + 1, "R10 one cycle per unknown byte", 32'(busy_cyc), 32'(n + 1));
            chk(n_got == 0 && bus_block == 1'b0, "R10 no side effects", 32'(n_got), 0);
        end

        // R9 first end opcode stops the run
        clear_img(8'h7F); put(8'h7F); put(8'hE0); put(8'h00); put(8'h00); put(8'h00); put(8'h00);
        load_img();
        run(0, 50);
        chk(busy_cyc == 1 && n_got == 0, "R9 stop at first end byte", 32'(busy_cyc), 1);
        // R9 end of memory
        clear_img(8'h00); load_img();
        run(0, 1000);
        chk(busy_cyc == 513, "R9 end of memory", 32'(busy_cyc), 513);

        // R11 truncated operand in last byte
        clear_img(8'h00); img[511] = 8'hE0; load_img();
        run(0, 1000);
        chk(busy_cyc == 513 && n_got == 0, "R11 truncated op abandoned", 32'(n_got), 0);
        chk(bus_addr == m_adr, "R11 address shadow unchanged", bus_addr, m_adr);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule